// File: doc/BRIEF.md
# Event Performance Monitor

This block sits beside a processor core and counts activity. It holds a small, configurable number of event counters and one cycle counter. Each event counter watches one line of an event input vector, picked by its own 8-bit event-type value. The cycle counter counts clock cycles, either every cycle or once per 64 cycles. Software controls the unit through a simple register bus. The bus has a 4-bit address, a write strobe, 32-bit write data and combinational read data.

The event counters are reached indirectly. A 5-bit select register picks one counter. A single count window and a single type window then read or write that counter. Each counter has a bit in three maps: the enable map, the interrupt-enable map and the overflow-flag map. The enable and interrupt-enable maps are changed through separate set and clear addresses. When a counter wraps, it latches a sticky overflow flag. One interrupt line is raised whenever a flagged counter also has its interrupt enabled.

Register offsets: 0x0 control, 0x1 enable-set, 0x2 enable-clear, 0x3 irq-enable-set, 0x4 irq-enable-clear, 0x5 overflow flags, 0x6 counter select, 0x7 cycle count, 0x8 selected event count, 0x9 selected event type. Any other offset reads 0.

Top module: `perf_mon_unit`

## Requirements
- R1: Control register (offset 0x0). Bit 0 is the global run enable, and writes keep only bits 5:0. A read returns the counter count NUM_CNT in bits 15:11, bits 0 and 3 to 5 as last written, and 0 in every other bit, including bits 1 and 2. After reset it reads NUM_CNT<<11.
- R2: An event counter adds one on a clock edge only when all of these hold: control bit 0 is set, its enable bit is set, its event-type value is below NUM_EVT_IN, and event_in at that index is high. With bit 0 clear, no counter changes.
- R3: The enable map has event counter n at bit n and the cycle counter at bit 31. Writing 1s to offset 0x1 sets those bits and writing 1s to offset 0x2 clears them; 0 bits leave the map as it was. Reading either offset returns the map. Bits that belong to no counter read 0. The map resets to 0.
- R4: Writing control bit 1 clears all event counters at that write. Writing control bit 2 clears the cycle counter and its prescaler at that write. Neither bit is stored.
- R5: With control bit 3 set, the cycle counter advances once every 64 enabled cycles, counted from its last clear.
- R6: A counter wraps from all ones to 0 when it counts. On that same clock edge it sets its bit in the overflow-flag map: bit n for event counter n, bit 31 for the cycle counter.
- R7: Overflow flags (offset 0x5) are sticky. Writing 1 to a bit clears that flag, writing 0 has no effect, and a flag being set on the same edge as its clear stays set. The flags reset to 0.
- R8: The interrupt-enable map uses the same bit layout as the enable map. It is set at offset 0x3, cleared at offset 0x4, and resets to 0. ovf_irq is high whenever some bit is set in both the flag map and the interrupt-enable map.
- R9: The cycle counter (offset 0x7) has no event selection. When enabled it counts clock cycles whatever event_in holds. A bus write loads its value.
- R10: The select register (offset 0x6) keeps the low 5 bits of a write and reads them back. Offsets 0x8 (32-bit count) and 0x9 (8-bit event type, upper write bits dropped) read and write the selected event counter.
- R11: With a select value of NUM_CNT or more, offsets 0x8 and 0x9 read 0, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| event_in | input | NUM_EVT_IN | Event pulse lines, one count per high cycle |
| ovf_irq | output | 1 | Combined overflow interrupt |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are driven to known values from the first clock edge and change only away from the rising edge. They also treat any bus write as a possible disturbance: the frozen-cycle-counter and sticky-flag checks are only armed on cycles with no write to the affected register. The stimulus meets these assumptions. It drives the bus on falling edges and holds event_in steady while the counters run. It also opens and closes every run window with a control write, so the counters only move between those two known writes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;
   localparam int SEL_W  = 5;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL   = 4'h0,
      RA_EN_SET = 4'h1,
      RA_EN_CLR = 4'h2,
      RA_IE_SET = 4'h3,
      RA_IE_CLR = 4'h4,
      RA_FLAG   = 4'h5,
      RA_SEL    = 4'h6,
      RA_CYCLE  = 4'h7,
      RA_EVCNT  = 4'h8,
      RA_EVTYPE = 4'h9
   } reg_addr_e;

   // control bit positions
   localparam int CB_RUN     = 0;
   localparam int CB_CLR_EV  = 1;
   localparam int CB_CLR_CYC = 2;
   localparam int CB_DIV     = 3;
   localparam int CTRL_KEEP  = 6;
   localparam int NUM_LSB    = 11;
   localparam int NUM_W      = 5;
   localparam int CYC_BIT    = 31;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
   parameter int CNT_W      = 32,
   parameter int EVT_W      = 8,
   parameter int NUM_EVT_IN = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  clr,
   input  logic                  wr_cnt,
   input  logic                  wr_type,
   input  logic [CNT_W-1:0]      wdata_cnt,
   input  logic [EVT_W-1:0]      wdata_type,
   input  logic [NUM_EVT_IN-1:0] event_in,
   output logic [CNT_W-1:0]      count,
   output logic [EVT_W-1:0]      evt_type,
   output logic                  wrap
);
   logic hit;
   logic step;

   always_comb begin
      hit = 1'b0;
      for (int e = 0; e < NUM_EVT_IN; e++) begin
         if (evt_type == EVT_W'(e)) hit = event_in[e];
      end
   end

   assign step = run & hit & ~clr & ~wr_cnt;
   assign wrap = step & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (wr_cnt) count <= wdata_cnt;
      else if (step)   count <= count + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       evt_type <= '0;
      else if (wr_type) evt_type <= wdata_type;
   end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_en,
   input  logic             clr,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic tick;
   logic step;

   generate
      if (PRE_W > 0) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (run) pre_q <= pre_q + PRE_W'(1);
         end
         assign tick = div_en ? (&pre_q) : 1'b1;
      end else begin : g_nopre
         logic unused_div;
         assign unused_div = div_en;
         assign tick = 1'b1;
      end
   endgenerate

   assign step = run & tick & ~clr & ~wr;
   assign wrap = step & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (wr)   count <= wdata;
      else if (step) count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
   parameter int NUM_CNT    = 4,
   parameter int NUM_EVT_IN = 16,
   parameter int CNT_W      = 32,
   parameter int EVT_W      = 8,
   parameter int PRE_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_EVT_IN-1:0] event_in,
   output logic                  ovf_irq
);
   import pmu_pkg::*;

   localparam logic [DATA_W-1:0] IMPL_MASK =
      (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));
   localparam logic [CTRL_KEEP-1:0] CTRL_STORE_MASK =
      ~((CTRL_KEEP'(1) << CB_CLR_EV) | (CTRL_KEEP'(1) << CB_CLR_CYC));

   generate
      if (NUM_CNT < 1 || NUM_CNT > 31) begin : g_bad_num
         $error("NUM_CNT must be within 1..31");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("CNT_W must be within 2..32");
      end
      if (EVT_W < 1 || EVT_W > 8 || NUM_EVT_IN > (1 << EVT_W)) begin : g_bad_evt
         $error("event type width too small for NUM_EVT_IN");
      end
   endgenerate

   // bus decode
   logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
   logic wr_flag, wr_sel, wr_cyc, wr_evcnt, wr_evtype;

   always_comb begin
      wr_ctrl   = bus_we && (bus_addr == RA_CTRL);
      wr_en_set = bus_we && (bus_addr == RA_EN_SET);
      wr_en_clr = bus_we && (bus_addr == RA_EN_CLR);
      wr_ie_set = bus_we && (bus_addr == RA_IE_SET);
      wr_ie_clr = bus_we && (bus_addr == RA_IE_CLR);
      wr_flag   = bus_we && (bus_addr == RA_FLAG);
      wr_sel    = bus_we && (bus_addr == RA_SEL);
      wr_cyc    = bus_we && (bus_addr == RA_CYCLE);
      wr_evcnt  = bus_we && (bus_addr == RA_EVCNT);
      wr_evtype = bus_we && (bus_addr == RA_EVTYPE);
   end

   // control and map registers
   logic [CTRL_KEEP-1:0] ctrl_q;
   logic [DATA_W-1:0]    en_q, ie_q, flag_q;
   logic [SEL_W-1:0]     sel_q;
   logic                 clr_ev, clr_cyc, run_all;
   logic [DATA_W-1:0]    wrap_map;
   logic [DATA_W-1:0]    flag_clr;

   assign clr_ev  = wr_ctrl & bus_wdata[CB_CLR_EV];
   assign clr_cyc = wr_ctrl & bus_wdata[CB_CLR_CYC];
   assign run_all = ctrl_q[CB_RUN];
   assign flag_clr = wr_flag ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_KEEP-1:0] & CTRL_STORE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         ie_q <= '0;
      end else begin
         if (wr_en_set)      en_q <= (en_q | bus_wdata) & IMPL_MASK;
         else if (wr_en_clr) en_q <= en_q & ~bus_wdata;
         if (wr_ie_set)      ie_q <= (ie_q | bus_wdata) & IMPL_MASK;
         else if (wr_ie_clr) ie_q <= ie_q & ~bus_wdata;
      end
   end

   // a new wrap wins over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= ((flag_q & ~flag_clr) | wrap_map) & IMPL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
   end

   // event counters
   logic [CNT_W-1:0] ev_count [NUM_CNT];
   logic [EVT_W-1:0] ev_type  [NUM_CNT];
   logic [NUM_CNT-1:0] ev_wrap;

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_evc
         logic hit_sel;
         assign hit_sel = (sel_q == SEL_W'(g));
         pmu_event_counter #(
            .CNT_W      (CNT_W),
            .EVT_W      (EVT_W),
            .NUM_EVT_IN (NUM_EVT_IN)
         ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run_all & en_q[g]),
            .clr        (clr_ev),
            .wr_cnt     (wr_evcnt & hit_sel),
            .wr_type    (wr_evtype & hit_sel),
            .wdata_cnt  (bus_wdata[CNT_W-1:0]),
            .wdata_type (bus_wdata[EVT_W-1:0]),
            .event_in   (event_in),
            .count      (ev_count[g]),
            .evt_type   (ev_type[g]),
            .wrap       (ev_wrap[g])
         );
      end
   endgenerate

   // cycle counter
   logic [CNT_W-1:0] cyc_count;
   logic             cyc_wrap;

   pmu_cycle_counter #(
      .CNT_W (CNT_W),
      .PRE_W (PRE_W)
   ) u_cyc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_all & en_q[CYC_BIT]),
      .div_en (ctrl_q[CB_DIV]),
      .clr    (clr_cyc),
      .wr     (wr_cyc),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .count  (cyc_count),
      .wrap   (cyc_wrap)
   );

   always_comb begin
      wrap_map = '0;
      wrap_map[NUM_CNT-1:0] = ev_wrap;
      wrap_map[CYC_BIT] = cyc_wrap;
   end

   assign ovf_irq = |(flag_q & ie_q);

   // read path
   logic [CNT_W-1:0] sel_cnt;
   logic [EVT_W-1:0] sel_type;

   always_comb begin
      sel_cnt  = '0;
      sel_type = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (sel_q == SEL_W'(k)) begin
            sel_cnt  = ev_count[k];
            sel_type = ev_type[k];
         end
      end
   end

   always_comb begin
      case (reg_addr_e'(bus_addr))
         RA_CTRL:   bus_rdata = {16'b0, NUM_W'(NUM_CNT), 5'b0, ctrl_q};
         RA_EN_SET,
         RA_EN_CLR: bus_rdata = en_q;
         RA_IE_SET,
         RA_IE_CLR: bus_rdata = ie_q;
         RA_FLAG:   bus_rdata = flag_q;
         RA_SEL:    bus_rdata = DATA_W'(sel_q);
         RA_CYCLE:  bus_rdata = DATA_W'(cyc_count);
         RA_EVCNT:  bus_rdata = DATA_W'(sel_cnt);
         RA_EVTYPE: bus_rdata = DATA_W'(sel_type);
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       bus_addr,
   input logic             bus_we,
   input logic [31:0]      bus_rdata,
   input logic             ovf_irq,
   input logic             run_q,
   input logic [31:0]      ie_map,
   input logic [31:0]      flag_map,
   input logic [CNT_W-1:0] cyc_count,
   input logic             cyc_wrap,
   input logic [4:0]       sel_idx
);
   localparam logic [4:0] NUM_SEL = 5'(NUM_CNT);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R1: pulse bits never read back as set
   a_r1_ctrl_pulse_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'h0) |-> (bus_rdata[2:1] == 2'b00));

   // R7: without a flag write, no flag drops
   a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(bus_we && bus_addr == 4'h5))
         |-> ((flag_map & $past(flag_map)) == $past(flag_map)));

   // R6: a cycle counter wrap leaves bit 31 flagged
   a_r6_cycle_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cyc_wrap)) |-> flag_map[31]);

   // R8: the interrupt only rises after a flag or enable change
   a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(ovf_irq))
         |-> (!$stable(flag_map) || !$stable(ie_map)));

   // R2: with the run bit clear and no write, the cycle counter holds
   a_r2_cycle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(run_q) && !$past(bus_we)) |-> $stable(cyc_count));

   // R11: out-of-range select reads 0 from both windows
   a_r11_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_addr == 4'h8 || bus_addr == 4'h9) && sel_idx >= NUM_SEL)
         |-> (bus_rdata == 32'h0));
endmodule

bind perf_mon_unit pmu_checker #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W)
) u_pmu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .ovf_irq   (ovf_irq),
   .run_q     (ctrl_q[0]),
   .ie_map    (ie_q),
   .flag_map  (flag_q),
   .cyc_count (cyc_count),
   .cyc_wrap  (cyc_wrap),
   .sel_idx   (sel_q)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
   localparam int NC = 4;
   localparam int NE = 16;
   localparam logic [3:0] A_CTRL = 4'h0, A_ENS = 4'h1, A_ENC = 4'h2, A_IES = 4'h3,
                          A_IEC = 4'h4, A_FLG = 4'h5, A_SEL = 4'h6, A_CYC = 4'h7,
                          A_CNT = 4'h8, A_TYP = 4'h9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NE-1:0] ev = '0;
   logic irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   perf_mon_unit #(.NUM_CNT(NC), .NUM_EVT_IN(NE)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdata), .event_in(ev), .ovf_irq(irq));

   always #5 clk = ~clk;

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; we = 1'b0; #1; d = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // counting edges between the two control writes equal k (k >= 2)
   task automatic run_for(input int k, input bit div);
      wr(A_CTRL, div ? 32'h9 : 32'h1);
      repeat (k - 2) @(negedge clk);
      wr(A_CTRL, div ? 32'h8 : 32'h0);
   endtask

   function automatic logic [32:0] ev_expect(input logic [31:0] st, input bit en,
                                             input logic [7:0] ty, input logic [NE-1:0] e,
                                             input int k);
      logic [32:0] inc = (en && ty < NE && e[ty[3:0]]) ? 33'(k) : 33'd0;
      return {1'b0, st} + inc;
   endfunction

   function automatic logic [32:0] cyc_expect(input logic [31:0] st, input bit en,
                                              input bit div, input int k);
      logic [32:0] inc = !en ? 33'd0 : (div ? 33'(k / 64) : 33'(k));
      return {1'b0, st} + inc;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd7151));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(A_CTRL, r); chk("R1 reset ctrl", r, 32'h0000_2000);
      rd(A_ENS, r);  chk("R3 reset enable map", r, 32'h0);
      rd(A_IES, r);  chk("R8 reset irq-enable map", r, 32'h0);
      rd(A_FLG, r);  chk("R7 reset flags", r, 32'h0);
      chk("R8 reset irq", 32'(irq), 32'h0);

      // control writable bits, pulse bits read 0
      wr(A_CTRL, 32'hFFFF_FFFF & ~32'h1);
      rd(A_CTRL, r); chk("R1 R4 ctrl write mask", r, 32'h0000_2038);
      wr(A_CTRL, 32'h0);

      // set / clear enable map
      wr(A_ENS, 32'h8000_0005); rd(A_ENC, r); chk("R3 set", r, 32'h8000_0005);
      wr(A_ENS, 32'h0000_0002); rd(A_ENS, r); chk("R3 set keeps", r, 32'h8000_0007);
      wr(A_ENC, 32'h0000_0004); rd(A_ENS, r); chk("R3 clear", r, 32'h8000_0003);
      wr(A_ENS, 32'h0000_0F00); rd(A_ENS, r); chk("R3 unmapped bits", r, 32'h8000_0003);
      wr(A_ENC, 32'hFFFF_FFFF); rd(A_ENS, r); chk("R3 clear all", r, 32'h0);

      // select windows
      wr(A_SEL, 32'h2); rd(A_SEL, r); chk("R10 select readback", r, 32'h2);
      wr(A_TYP, 32'h1A5); rd(A_TYP, r); chk("R10 type 8 bits", r, 32'hA5);
      wr(A_CNT, 32'hDEAD_BEEF); rd(A_CNT, r); chk("R10 count window", r, 32'hDEAD_BEEF);
      wr(A_SEL, 32'h25); rd(A_SEL, r); chk("R10 select 5 bits", r, 32'h5);
      rd(A_CNT, r); chk("R11 oob count reads 0", r, 32'h0);
      rd(A_TYP, r); chk("R11 oob type reads 0", r, 32'h0);
      wr(A_CNT, 32'h1234); wr(A_TYP, 32'h3);
      wr(A_SEL, 32'h2);
      rd(A_CNT, r); chk("R11 oob write ignored count", r, 32'hDEAD_BEEF);
      rd(A_TYP, r); chk("R11 oob write ignored type", r, 32'hA5);
      for (int i = 0; i < NC; i++) begin
         if (i != 2) begin
            wr(A_SEL, 32'(i)); rd(A_CNT, r); chk("R11 oob write other counter", r, 32'h0);
         end
      end

      // global enable off: nothing counts
      wr(A_SEL, 32'h2); wr(A_TYP, 32'h0); ev = '1;
      wr(A_ENS, 32'h8000_0004);
      repeat (20) @(negedge clk);
      rd(A_CNT, r); chk("R2 global off holds count", r, 32'hDEAD_BEEF);
      rd(A_CYC, r); chk("R2 global off holds cycle", r, 32'h0);
      wr(A_ENC, 32'hFFFF_FFFF);

      // cycle counter wrap, flag, irq, W1C
      ev = '0;
      wr(A_CTRL, 32'h6); wr(A_CYC, 32'hFFFF_FFFE); wr(A_ENS, 32'h8000_0000);
      run_for(3, 1'b0);
      rd(A_CYC, r); chk("R9 R6 cycle wraps without events", r, 32'h1);
      rd(A_FLG, r); chk("R6 wrap flag", r, 32'h8000_0000);
      chk("R8 no irq without enable", 32'(irq), 32'h0);
      wr(A_IES, 32'h8000_0000); @(negedge clk); #1;
      chk("R8 irq when enabled", 32'(irq), 32'h1);
      wr(A_FLG, 32'h0); rd(A_FLG, r); chk("R7 write 0 keeps flag", r, 32'h8000_0000);
      wr(A_FLG, 32'h8000_0000); rd(A_FLG, r); chk("R7 write 1 clears", r, 32'h0);
      chk("R8 irq drops", 32'(irq), 32'h0);
      wr(A_IEC, 32'hFFFF_FFFF);

      // reset bits
      wr(A_CTRL, 32'h6); wr(A_SEL, 32'h0); wr(A_TYP, 32'h0); wr(A_CNT, 32'd100);
      wr(A_CYC, 32'd500); wr(A_ENS, 32'h8000_0001); ev = 16'h0001;
      run_for(10, 1'b0);
      rd(A_CNT, r); chk("R2 counts while enabled", r, 32'd110);
      wr(A_CTRL, 32'h2);
      rd(A_CNT, r); chk("R4 event reset", r, 32'h0);
      rd(A_CYC, r); chk("R4 event reset spares cycle", r, 32'd510);
      wr(A_CTRL, 32'h4);
      rd(A_CYC, r); chk("R4 cycle reset", r, 32'h0);

      // prescaler
      run_for(130, 1'b1);
      rd(A_CYC, r); chk("R5 divide by 64", r, 32'd2);
      wr(A_CTRL, 32'h4); wr(A_ENC, 32'hFFFF_FFFF);

      // random trials
      for (int t = 0; t < 24; t++) begin
         logic [31:0] st [NC];
         logic [7:0]  ty [NC];
         logic [31:0] cst, enm, iem, fexp;
         logic [32:0] s;
         bit d;
         int k;
         logic [NE-1:0] e;
         enm = {$urandom_range(0, 1) == 1, 27'b0, 4'($urandom_range(0, 15))};
         iem = {$urandom_range(0, 1) == 1, 27'b0, 4'($urandom_range(0, 15))};
         d = ($urandom_range(0, 2) == 0);
         k = $urandom_range(2, 200);
         e = NE'($urandom);
         cst = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF - $urandom_range(0, 200) : $urandom;
         wr(A_CTRL, 32'h6); wr(A_FLG, 32'hFFFF_FFFF);
         wr(A_ENC, 32'hFFFF_FFFF); wr(A_IEC, 32'hFFFF_FFFF);
         for (int i = 0; i < NC; i++) begin
            ty[i] = 8'($urandom_range(0, 19));
            st[i] = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF - $urandom_range(0, 200) : $urandom;
            wr(A_SEL, 32'(i)); wr(A_TYP, 32'(ty[i])); wr(A_CNT, st[i]);
         end
         wr(A_CYC, cst); wr(A_ENS, enm); wr(A_IES, iem); ev = e;
         run_for(k, d);
         fexp = '0;
         for (int i = 0; i < NC; i++) begin
            s = ev_expect(st[i], enm[i], ty[i], e, k);
            fexp[i] = s[32];
            wr(A_SEL, 32'(i)); rd(A_CNT, r);
            chk("R2 R6 random event count", r, s[31:0]);
         end
         s = cyc_expect(cst, enm[31], d, k);
         fexp[31] = s[32];
         rd(A_CYC, r); chk("R9 R5 random cycle count", r, s[31:0]);
         rd(A_FLG, r); chk("R6 random flags", r, fexp);
         chk("R8 random irq", 32'(irq), 32'(|(fexp & iem)));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule